// File: doc/BRIEF.md
# PLL Relock and Status Controller

This block is the control state machine that sits beside a reference-locked clock PLL. Software, through a register bus outside this block, issues a single-cycle relock strobe. The controller then tells the loop to start a fresh acquisition of the selected reference. Once the loop reports lock, it issues the follow-up command that the frame-phase mode calls for. In align mode that command picks the frame edge again. In arbitrary mode it restarts phase rebuild.

The controller also builds a status word. The word carries a synchronized flag, a loss-of-signal flag and a loss-of-lock flag. It also carries two flags that say whether the short-term frequency history and the device holdover history are usable. The three timing flags read zero whenever the device runs from its own oscillator (self-timing). An acquisition that does not reach lock within a programmable number of cycles is reported as loss of lock.

The analog loop, the phase detector and the register decoding are outside this block. Level and strobe inputs stand in for them.

Top module: `pll_relock_ctrl`

## Requirements
- R1: With `ext_timing`=1, a `relock_evt` strobe sampled on a clock edge makes `cmd_acquire` high for exactly the following cycle and clears the LOL status bit (bit 2).
- R2: With `frame_align`=1, the first edge during acquisition at which `lock_det` and `ref_active` are both high produces a one-cycle `cmd_frame_resel` pulse in the following cycle, and no `cmd_phase_rebuild`.
- R3: With `frame_align`=0, the same lock event produces a one-cycle `cmd_phase_rebuild` pulse instead, and no `cmd_frame_resel`.
- R4: With `ext_timing`=0, status bits 0 (SYNC), 1 (LOS) and 2 (LOL) read zero, and a relock strobe produces no command pulse.
- R5: If `lock_det` stays low after a relock strobe, LOL (bit 2) becomes set exactly `acq_limit` cycles after the edge that sampled the strobe, and not earlier. `acq_limit` must be nonzero.
- R6: Once acquisition has reached lock, a drop of `lock_det` while `ref_active` is high sets LOL on the next edge.
- R7: A relock strobe received during acquisition restarts the timeout count from zero. The request is not queued.
- R8: SYNC (bit 0) is high only after `align_done` has moved the controller into the locked state. It falls in the same cycle that `lock_det` falls, `ref_active` falls, or a relock strobe is seen.
- R9: In external timing, LOS (bit 1) follows the inverse of `ref_active`, and loss of the reference ends any acquisition or lock without setting LOL.
- R10: Bit 3 shows `short_hist_ready`. Bit 4 (holdover history available) becomes set on the edge after the locked state coincides with `short_hist_ready`. It is then kept through LOS, LOL and self-timing until reset.
- R11: After reset all command outputs are low and the status word is zero while `short_hist_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_timing | input | 1 | 1 = external timing, 0 = self-timing |
| frame_align | input | 1 | 1 = frame-phase align, 0 = frame-phase arbitrary |
| relock_evt | input | 1 | One-cycle relock request strobe |
| ref_active | input | 1 | Selected reference shows activity |
| lock_det | input | 1 | Loop lock indication |
| align_done | input | 1 | Frame-edge reselection or phase rebuild complete |
| short_hist_ready | input | 1 | Short-term history has matured |
| acq_limit | input | CNT_W | Acquisition timeout in cycles (nonzero) |
| cmd_acquire | output | 1 | Pulse: restart acquisition |
| cmd_frame_resel | output | 1 | Pulse: reselect frame edge |
| cmd_phase_rebuild | output | 1 | Pulse: restart phase rebuild |
| status | output | 5 | {hold_avail, short_avail, LOL, LOS, SYNC} |

## Verification
The relock sequence is driven from a table of cases that change the frame-phase mode and the delay before lock is reported. This tells the align follow-up apart from the rebuild follow-up. It also separates a lock that arrives in time from one that arrives only after the timeout. A case that locks on the first cycle of acquisition and one that locks on the last allowed cycle test the priority of lock over timeout. Directed sequences then cover several cases. One is a second strobe during acquisition, which shows the timer restarting rather than running on. Others are loss of the reference while locked, which separates LOS from LOL, the self-timing mask, and the stickiness of the holdover flag across reference loss, mode change and reset.

// File: rtl/pll_relock_pkg.sv
// Package: shared state encoding and status bit positions for the
// PLL relock controller. Assumes a 5-bit status word.
package pll_relock_pkg;

    typedef enum logic [1:0] {
        ST_IDLE          = 2'd0,
        ST_ACQUIRE       = 2'd1,
        ST_ALIGN_REBUILD = 2'd2,
        ST_LOCKED        = 2'd3
    } relock_state_e;

    localparam int STAT_W  = 5;
    localparam int SB_SYNC = 0;
    localparam int SB_LOS  = 1;
    localparam int SB_LOL  = 2;
    localparam int SB_SHORT = 3;
    localparam int SB_HOLD = 4;

endpackage

// File: rtl/relock_timer.sv
// Module: acquisition timeout counter. It counts the cycles spent in the
// acquire state and flags the cycle on which the programmed limit is
// reached. Assumes limit is nonzero. Clear has priority over run.
module relock_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // Last count value before the limit is reached.
    assign last    = limit - CNT_W'(1);
    assign expired = run && (cnt == last);

    // Counter: reset or clear to zero, otherwise step while running.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/relock_fsm.sv
// Module: relock sequencing state machine. It moves through idle,
// acquire, align-or-rebuild and locked. It issues registered one-cycle
// commands to the loop and keeps the loss-of-lock flag. Assumes
// relock_evt is a single-cycle strobe. Self-timing forces idle.
module relock_fsm
    import pll_relock_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_timing,
    input  logic          relock_evt,
    input  logic          frame_align,
    input  logic          ref_active,
    input  logic          lock_det,
    input  logic          align_done,
    input  logic          tmr_expired,
    output relock_state_e state,
    output logic          tmr_clear,
    output logic          tmr_run,
    output logic          lol_flag,
    output logic          cmd_acquire,
    output logic          cmd_frame_resel,
    output logic          cmd_phase_rebuild
);

    relock_state_e nxt_state;
    logic          nxt_lol;
    logic          nxt_acq;
    logic          nxt_resel;
    logic          nxt_rebuild;

    assign tmr_clear = relock_evt || (state != ST_ACQUIRE);
    assign tmr_run   = (state == ST_ACQUIRE);

    // Next-state and command decode. Order of priority: mode, relock, then state.
    always_comb begin
        nxt_state   = state;
        nxt_lol     = lol_flag;
        nxt_acq     = 1'b0;
        nxt_resel   = 1'b0;
        nxt_rebuild = 1'b0;
        if (!ext_timing) begin
            nxt_state = ST_IDLE;
            nxt_lol   = 1'b0;
        end else if (relock_evt) begin
            nxt_state = ST_ACQUIRE;
            nxt_lol   = 1'b0;
            nxt_acq   = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: nxt_state = ST_IDLE;
                ST_ACQUIRE: begin
                    if (!ref_active) begin
                        nxt_state = ST_IDLE;
                    end else if (lock_det) begin
                        nxt_state   = ST_ALIGN_REBUILD;
                        nxt_resel   = frame_align;
                        nxt_rebuild = !frame_align;
                    end else if (tmr_expired) begin
                        nxt_state = ST_IDLE;
                        nxt_lol   = 1'b1;
                    end
                end
                ST_ALIGN_REBUILD, ST_LOCKED: begin
                    if (!ref_active) begin
                        nxt_state = ST_IDLE;
                    end else if (!lock_det) begin
                        nxt_state = ST_IDLE;
                        nxt_lol   = 1'b1;
                    end else if (align_done) begin
                        nxt_state = ST_LOCKED;
                    end
                end
                default: nxt_state = ST_IDLE;
            endcase
        end
    end

    // State, flag and command registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state             <= ST_IDLE;
            lol_flag          <= 1'b0;
            cmd_acquire       <= 1'b0;
            cmd_frame_resel   <= 1'b0;
            cmd_phase_rebuild <= 1'b0;
        end else begin
            state             <= nxt_state;
            lol_flag          <= nxt_lol;
            cmd_acquire       <= nxt_acq;
            cmd_frame_resel   <= nxt_resel;
            cmd_phase_rebuild <= nxt_rebuild;
        end
    end

endmodule

// File: rtl/relock_status.sv
// Module: status word builder. SYNC, LOS and LOL are masked outside
// external timing. SYNC drops in the same cycle as its cause. The
// holdover-available flag is sticky until reset.
module relock_status
    import pll_relock_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_timing,
    input  logic                relock_evt,
    input  relock_state_e       state,
    input  logic                ref_active,
    input  logic                lock_det,
    input  logic                lol_flag,
    input  logic                short_hist_ready,
    output logic [STAT_W-1:0]   status
);

    logic hold_avail;

    // Sticky holdover-history flag: set when locked with a mature short history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_avail <= 1'b0;
        end else if (state == ST_LOCKED && short_hist_ready) begin
            hold_avail <= 1'b1;
        end
    end

    // Status assembly with self-timing mask on the three timing flags.
    always_comb begin
        status           = '0;
        status[SB_SYNC]  = ext_timing && (state == ST_LOCKED) && ref_active
                           && lock_det && !relock_evt;
        status[SB_LOS]   = ext_timing && !ref_active;
        status[SB_LOL]   = ext_timing && lol_flag;
        status[SB_SHORT] = short_hist_ready;
        status[SB_HOLD]  = hold_avail;
    end

endmodule

// File: rtl/pll_relock_ctrl.sv
// Module: top of the PLL relock and status controller. It connects the
// sequencing FSM, the acquisition timeout counter and the status
// builder. Assumes all inputs are synchronous to clk.
module pll_relock_ctrl
    import pll_relock_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_timing,
    input  logic             frame_align,
    input  logic             relock_evt,
    input  logic             ref_active,
    input  logic             lock_det,
    input  logic             align_done,
    input  logic             short_hist_ready,
    input  logic [CNT_W-1:0] acq_limit,
    output logic             cmd_acquire,
    output logic             cmd_frame_resel,
    output logic             cmd_phase_rebuild,
    output logic [4:0]       status
);

    relock_state_e state;
    logic          tmr_clear;
    logic          tmr_run;
    logic          tmr_expired;
    logic          lol_flag;

    relock_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .limit   (acq_limit),
        .expired (tmr_expired)
    );

    relock_fsm u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .ext_timing        (ext_timing),
        .relock_evt        (relock_evt),
        .frame_align       (frame_align),
        .ref_active        (ref_active),
        .lock_det          (lock_det),
        .align_done        (align_done),
        .tmr_expired       (tmr_expired),
        .state             (state),
        .tmr_clear         (tmr_clear),
        .tmr_run           (tmr_run),
        .lol_flag          (lol_flag),
        .cmd_acquire       (cmd_acquire),
        .cmd_frame_resel   (cmd_frame_resel),
        .cmd_phase_rebuild (cmd_phase_rebuild)
    );

    relock_status u_status (
        .clk              (clk),
        .rst_n            (rst_n),
        .ext_timing       (ext_timing),
        .relock_evt       (relock_evt),
        .state            (state),
        .ref_active       (ref_active),
        .lock_det         (lock_det),
        .lol_flag         (lol_flag),
        .short_hist_ready (short_hist_ready),
        .status           (status)
    );

endmodule

// File: rtl/pll_relock_ctrl_chk.sv
// Module: checker for the relock controller, bound to the top. It
// observes the ports only and drives nothing.
module pll_relock_ctrl_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_timing,
    input logic             frame_align,
    input logic             relock_evt,
    input logic             ref_active,
    input logic             lock_det,
    input logic             align_done,
    input logic             short_hist_ready,
    input logic [CNT_W-1:0] acq_limit,
    input logic             cmd_acquire,
    input logic             cmd_frame_resel,
    input logic             cmd_phase_rebuild,
    input logic [4:0]       status
);

    // R1
    relock_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (relock_evt && ext_timing) |=> (cmd_acquire && !status[2]));

    // R2
    resel_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_frame_resel |-> ($past(frame_align) && !cmd_phase_rebuild));

    // R3
    rebuild_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_phase_rebuild |-> !$past(frame_align));

    // R4
    self_timing_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_timing |-> (status[2:0] == 3'b000));

    // R6
    lock_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !lock_det && ref_active && ext_timing && !relock_evt)
        |=> (status[2] || !ext_timing || relock_evt));

    // R8
    sync_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> (!status[1] && !status[2] && lock_det));

    // R10
    hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[4] |=> status[4]);

    // R4
    no_cmd_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_timing && relock_evt) |=> !cmd_acquire);

endmodule

bind pll_relock_ctrl pll_relock_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pll_relock_ctrl_test.sv
// Bench for the relock controller: a table-driven relock sweep followed by
// directed reset and corner-case sequences.
module pll_relock_ctrl_test;

    localparam int CNT_W = 16;
    localparam int LIMIT = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_timing = 1'b0;
    logic             frame_align = 1'b0;
    logic             relock_evt = 1'b0;
    logic             ref_active = 1'b0;
    logic             lock_det = 1'b0;
    logic             align_done = 1'b0;
    logic             short_hist_ready = 1'b0;
    logic [CNT_W-1:0] acq_limit = CNT_W'(LIMIT);
    logic             cmd_acquire;
    logic             cmd_frame_resel;
    logic             cmd_phase_rebuild;
    logic [4:0]       status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pll_relock_ctrl #(.CNT_W(CNT_W)) uut (
        .clk               (clk),
        .rst_n             (rst_n),
        .ext_timing        (ext_timing),
        .frame_align       (frame_align),
        .relock_evt        (relock_evt),
        .ref_active        (ref_active),
        .lock_det          (lock_det),
        .align_done        (align_done),
        .short_hist_ready  (short_hist_ready),
        .acq_limit         (acq_limit),
        .cmd_acquire       (cmd_acquire),
        .cmd_frame_resel   (cmd_frame_resel),
        .cmd_phase_rebuild (cmd_phase_rebuild),
        .status            (status)
    );

    typedef struct packed {
        logic       align;
        logic [7:0] delay;
        logic       exp_resel;
        logic       exp_rebuild;
        logic       exp_lol;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b1, 8'd0,  1'b1, 1'b0, 1'b0},
        '{1'b0, 8'd0,  1'b0, 1'b1, 1'b0},
        '{1'b1, 8'd7,  1'b1, 1'b0, 1'b0},
        '{1'b0, 8'd19, 1'b0, 1'b1, 1'b0},
        '{1'b1, 8'd25, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic strobe_relock();
        relock_evt = 1'b1;
        @(negedge clk);
        relock_evt = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 status", 32'(status), 32'h0);
        chk("R11 cmds", 32'({cmd_acquire, cmd_frame_resel, cmd_phase_rebuild}), 32'h0);
        rst_n = 1'b1;
        ext_timing = 1'b1;
        ref_active = 1'b1;
        @(negedge clk);
        chk("R11 status after release", 32'(status), 32'h0);

        // Table sweep: R1, R2, R3, R5, R6, R8
        for (int i = 0; i < 5; i++) begin
            frame_align = VECS[i].align;
            lock_det = 1'b0;
            strobe_relock();
            chk("R1 cmd_acquire", 32'(cmd_acquire), 32'h1);
            chk("R1 LOL cleared", 32'(status[2]), 32'h0);
            repeat (int'(VECS[i].delay)) @(negedge clk);
            lock_det = 1'b1;
            @(negedge clk);
            chk(VECS[i].align ? "R2 resel" : "R3 resel", 32'(cmd_frame_resel), 32'(VECS[i].exp_resel));
            chk(VECS[i].align ? "R2 rebuild" : "R3 rebuild", 32'(cmd_phase_rebuild), 32'(VECS[i].exp_rebuild));
            chk("R5 LOL by table", 32'(status[2]), 32'(VECS[i].exp_lol));
            if (!VECS[i].exp_lol) begin
                @(negedge clk);
                chk("R2 single pulse", 32'({cmd_frame_resel, cmd_phase_rebuild}), 32'h0);
                chk("R8 no SYNC before align_done", 32'(status[0]), 32'h0);
                align_done = 1'b1;
                @(negedge clk);
                align_done = 1'b0;
                chk("R8 SYNC in locked", 32'(status[0]), 32'h1);
                lock_det = 1'b0;
                #1;
                chk("R8 SYNC drops with lock", 32'(status[0]), 32'h0);
                @(negedge clk);
                chk("R6 LOL on lock loss", 32'(status[2]), 32'h1);
            end
        end

        // R5: exact timeout boundary
        lock_det = 1'b0;
        strobe_relock();
        repeat (LIMIT - 1) @(negedge clk);
        chk("R5 no LOL before limit", 32'(status[2]), 32'h0);
        @(negedge clk);
        chk("R5 LOL at limit", 32'(status[2]), 32'h1);

        // R7: second strobe restarts the timer
        strobe_relock();
        repeat (10) @(negedge clk);
        strobe_relock();
        chk("R7 second cmd_acquire", 32'(cmd_acquire), 32'h1);
        repeat (LIMIT - 1) @(negedge clk);
        chk("R7 timer restarted", 32'(status[2]), 32'h0);
        @(negedge clk);
        chk("R7 LOL after restart", 32'(status[2]), 32'h1);

        // R8: relock strobe drops SYNC at once; R10 holdover flag
        frame_align = 1'b0;
        strobe_relock();
        lock_det = 1'b1;
        @(negedge clk);
        align_done = 1'b1;
        @(negedge clk);
        align_done = 1'b0;
        chk("R8 SYNC set", 32'(status[0]), 32'h1);
        relock_evt = 1'b1;
        #1;
        chk("R8 SYNC drops on relock", 32'(status[0]), 32'h0);
        @(negedge clk);
        relock_evt = 1'b0;
        @(negedge clk);
        align_done = 1'b1;
        @(negedge clk);
        align_done = 1'b0;
        chk("R10 hold not yet", 32'(status[4]), 32'h0);
        short_hist_ready = 1'b1;
        #1;
        chk("R10 short flag", 32'(status[3]), 32'h1);
        @(negedge clk);
        chk("R10 hold set", 32'(status[4]), 32'h1);

        // R9: reference loss
        ref_active = 1'b0;
        #1;
        chk("R9 LOS", 32'(status[1]), 32'h1);
        chk("R9 SYNC drops", 32'(status[0]), 32'h0);
        @(negedge clk);
        chk("R9 no LOL on LOS", 32'(status[2]), 32'h0);
        chk("R10 hold kept through LOS", 32'(status[4]), 32'h1);

        // R4: self-timing mask and ignored relock
        ext_timing = 1'b0;
        #1;
        chk("R4 timing flags masked", 32'(status[2:0]), 32'h0);
        strobe_relock();
        chk("R4 no acquire", 32'(cmd_acquire), 32'h0);
        @(negedge clk);
        chk("R4 no follow-up", 32'({cmd_frame_resel, cmd_phase_rebuild}), 32'h0);
        chk("R10 hold kept in self-timing", 32'(status[4]), 32'h1);

        // R11: reset clears the sticky flag
        short_hist_ready = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset clears status", 32'(status), 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule